// File: doc/BRIEF.md
# Receive FIFO with error tags

This block is the character buffer between a serial receiver and the CPU's read path. Each character the receiver finishes is pushed with three error tags: parity error, framing error and break. The tags travel with the character and come out beside it when that character reaches the head. The CPU drains the buffer through a show-ahead read port. A request output rises once the fill count reaches a programmable trigger level. A summary flag reports whether any character still held carries a tag.

The receiver side is a valid/ready port, but the receiver cannot stall. A character it presents while `wr_ready` is low is not retried. It is discarded, and the sticky overrun flag is set. `wr_ready` is high while the buffer has a free slot. It is also high in a cycle in which the read port completes a transfer, so a full buffer that is read and written in the same cycle accepts the new character. The read port follows the same rules: `rd_valid` means that the head entry is on `rd_data` and the tag outputs, and a transfer happens on every cycle with `rd_valid` and `rd_ready` both high. A flush input empties the buffer in one cycle. A clear input models the CPU reading the line status and drops the overrun flag.

Top module: `rx_tag_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `fill` is 0, `rd_valid`, `rx_req`, `err_any` and `overrun` are 0, and `wr_ready` is 1.
- R2: Characters leave in the order they were accepted. While `rd_valid` is high, `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` show the oldest entry. These outputs stay unchanged until a read transfer or a flush. `rd_valid` is high exactly when `fill` is nonzero.
- R3: `wr_ready` equals (`fill` < DEPTH) OR (`rd_valid` AND `rd_ready`). A write with `wr_valid` and `wr_ready` both high and `flush` low is stored. `fill` never exceeds DEPTH.
- R4: A write presented while `wr_ready` is low and `flush` is low is discarded: the stored contents do not change. `overrun` is 1 from the next cycle.
- R5: When the buffer is full and a read transfer and a write happen in the same cycle, both take effect. `fill` stays at DEPTH, and `overrun` is not set by that write.
- R6: `overrun` stays set until a cycle with `ovr_clr` high. If a discarded write and `ovr_clr` fall in the same cycle, `overrun` stays set.
- R7: `trig_sel` picks the trigger level: 0 selects 1, 1 selects DEPTH/4, 2 selects DEPTH/2 and 3 selects DEPTH-2. `rx_req` is high when `rx_int_en` is high and `fill` is at or above the selected level. It follows `fill` and the select in the same cycle.
- R8: With `rx_int_en` low, `rx_req` is 0 at every fill level.
- R9: `err_any` is 1 exactly when at least one held entry has any of its three tags set. It returns to 0 in the cycle after the last tagged entry is read.
- R10: A cycle with `flush` high leaves `fill`, `rd_valid` and `err_any` at 0 in the next cycle. A write presented in that cycle is discarded without setting `overrun`. `overrun` itself is not affected by the flush.
- R11: `fill` changes by at most one per cycle outside a flush. It goes up by one for an accepted write without a read, and down by one for a read without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Receiver presents a finished character |
| wr_ready | output | 1 | Buffer can take the character this cycle |
| wr_data | input | DW | Received character |
| wr_perr | input | 1 | Parity error tag of the character |
| wr_ferr | input | 1 | Framing error tag of the character |
| wr_brk | input | 1 | Break tag of the character |
| rd_valid | output | 1 | Head entry is presented |
| rd_ready | input | 1 | CPU takes the head entry |
| rd_data | output | DW | Head character |
| rd_perr | output | 1 | Head parity error tag |
| rd_ferr | output | 1 | Head framing error tag |
| rd_brk | output | 1 | Head break tag |
| trig_sel | input | 2 | Trigger level code |
| rx_int_en | input | 1 | Enables the data-available request |
| flush | input | 1 | Empties the buffer |
| ovr_clr | input | 1 | Clears the overrun flag |
| fill | output | $clog2(DEPTH+1) | Number of held entries |
| rx_req | output | 1 | Data-available request |
| err_any | output | 1 | Some held entry carries an error tag |
| overrun | output | 1 | Sticky flag for a discarded character |

## Verification
A bad pointer or a bad count shows up at the read port in the cycle after the faulty update. It appears as a wrong head character or tag, or as `rd_valid` disagreeing with `fill`. A bad error-tag counter leaves `err_any` set after the buffer has emptied, or clear while a tagged entry is held, and this is visible one cycle after the push or pop that went wrong. Every cycle, a queue model in the bench predicts the fill count, the head entry, the request, the summary flag and the overrun flag, including the full-and-read case and flushes that race a write. Any divergence is therefore caught in the cycle it first becomes visible at the ports.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int DATA_W = 8;

  // One buffered character with its receive-error tags.
  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  // Trigger level for a 2-bit select code, scaled by the buffer depth.
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    flush,
  input  logic    push,
  input  logic    pop,
  input  rx_ent_t push_ent,
  output rx_ent_t head_ent
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
    end
  end

  assign head_ent = mem[rp];

endmodule

// File: rtl/rxf_level.sv
module rxf_level
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [1:0]    trig_sel,
  input  logic          int_en,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          req
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] lvl_tab [4];

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_lvl
      assign lvl_tab[g] = CW'(trig_level(2'(g), DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count <= '0;
    end else begin
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign req   = int_en && (count >= lvl_tab[trig_sel]);

endmodule

// File: rtl/rxf_errtrack.sv
module rxf_errtrack
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic push,
  input  logic pop,
  input  logic push_tagged,
  input  logic head_tagged,
  output logic any_tagged
);

  logic [CW-1:0] tagged_cnt;
  logic          inc;
  logic          dec;

  assign inc = push && push_tagged;
  assign dec = pop && head_tagged;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      tagged_cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   tagged_cnt <= tagged_cnt + 1'b1;
        2'b01:   tagged_cnt <= tagged_cnt - 1'b1;
        default: tagged_cnt <= tagged_cnt;
      endcase
    end
  end

  assign any_tagged = (tagged_cnt != '0);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = DATA_W,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  input  logic [1:0]    trig_sel,
  input  logic          rx_int_en,
  input  logic          flush,
  input  logic          ovr_clr,
  output logic [CW-1:0] fill,
  output logic          rx_req,
  output logic          err_any,
  output logic          overrun
);

  logic    full;
  logic    empty;
  logic    rd_fire;
  logic    push;
  logic    pop;
  logic    drop;
  rx_ent_t in_ent;
  rx_ent_t head;

  assign in_ent.data = wr_data;
  assign in_ent.par  = wr_perr;
  assign in_ent.frm  = wr_ferr;
  assign in_ent.brk  = wr_brk;

  assign rd_fire  = rd_ready && !empty;
  assign wr_ready = !full || rd_fire;
  assign push     = wr_valid && wr_ready && !flush;
  assign pop      = rd_fire && !flush;
  assign drop     = wr_valid && !wr_ready && !flush;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push     (push),
    .pop      (pop),
    .push_ent (in_ent),
    .head_ent (head)
  );

  rxf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push     (push),
    .pop      (pop),
    .trig_sel (trig_sel),
    .int_en   (rx_int_en),
    .count    (fill),
    .full     (full),
    .empty    (empty),
    .req      (rx_req)
  );

  rxf_errtrack #(.DEPTH(DEPTH), .CW(CW)) u_err (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .push        (push),
    .pop         (pop),
    .push_tagged (wr_perr || wr_ferr || wr_brk),
    .head_tagged (head.par || head.frm || head.brk),
    .any_tagged  (err_any)
  );

  // Sticky overrun: a dropped character wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assign rd_valid = !empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.par;
  assign rd_ferr  = head.frm;
  assign rd_brk   = head.brk;

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_perr,
  input logic          rd_ferr,
  input logic          rd_brk,
  input logic          rx_int_en,
  input logic          flush,
  input logic          ovr_clr,
  input logic [CW-1:0] fill,
  input logic          rx_req,
  input logic          err_any,
  input logic          overrun
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT);

  p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !flush) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_perr) && $stable(rd_ferr) && $stable(rd_brk)));

  p_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !flush) |=> overrun);

  p_full_rw_r5: assert property (@(posedge clk) disable iff (rst)
    (fill == FULL_CNT && wr_valid && rd_ready && !flush && !ovr_clr) |=>
      (fill == FULL_CNT) && (overrun == $past(overrun)));

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  p_req_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_int_en |-> !rx_req);

  p_err_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> !err_any);

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill == '0) && !rd_valid && !err_any);

  p_fill_step_r11: assert property (@(posedge clk) disable iff (rst)
    !flush |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
               (fill == $past(fill) - 1'b1));

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;

  localparam int D  = 16;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          wr_perr = 1'b0;
  logic          wr_ferr = 1'b0;
  logic          wr_brk = 1'b0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [7:0]    rd_data;
  logic          rd_perr;
  logic          rd_ferr;
  logic          rd_brk;
  logic [1:0]    trig_sel = 2'd0;
  logic          rx_int_en = 1'b1;
  logic          flush = 1'b0;
  logic          ovr_clr = 1'b0;
  logic [CW-1:0] fill;
  logic          rx_req;
  logic          err_any;
  logic          overrun;

  int total = 0;
  int bad   = 0;

  // Reference model state: entry = {brk, ferr, perr, data}
  logic [10:0] q[$];
  bit          m_ovr = 0;

  always #2 clk = ~clk;

  rx_tag_fifo #(.DEPTH(D)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0:    return 1;
      2'd1:    return D / 4;
      2'd2:    return D / 2;
      default: return D - 2;
    endcase
  endfunction

  // Per-cycle model update and comparison.
  always begin
    @(posedge clk);
    if (rst) begin
      q.delete();
      m_ovr = 0;
    end else if (flush) begin
      q.delete();
      if (ovr_clr) m_ovr = 0;
    end else begin
      bit rd_go;
      bit room;
      rd_go = rd_ready && (q.size() > 0);
      room  = (q.size() < D) || rd_go;
      if (rd_go) void'(q.pop_front());
      if (wr_valid && room) q.push_back({wr_brk, wr_ferr, wr_perr, wr_data});
      if (wr_valid && !room) m_ovr = 1;
      else if (ovr_clr)      m_ovr = 0;
    end
    #1;
    if (!rst) begin
      bit anyt;
      anyt = 0;
      foreach (q[i]) if (q[i][10:8] != 3'b000) anyt = 1;
      chk("R11 fill", int'(fill), q.size());
      chk("R2 rd_valid", int'(rd_valid), int'(q.size() > 0));
      if (q.size() > 0) chk("R2 head entry", int'({rd_brk, rd_ferr, rd_perr, rd_data}), int'(q[0]));
      chk("R3 wr_ready", int'(wr_ready), int'((q.size() < D) || (rd_ready && q.size() > 0)));
      chk("R9 err_any", int'(err_any), int'(anyt));
      chk("R6 overrun", int'(overrun), int'(m_ovr));
      chk("R7 rx_req", int'(rx_req), int'(rx_int_en && (q.size() >= lvl(trig_sel))));
    end
  end

  task automatic drive(input bit wv, input logic [7:0] d, input logic [2:0] tags, input bit rr);
    @(negedge clk);
    wr_valid = wv;
    wr_data  = d;
    {wr_brk, wr_ferr, wr_perr} = tags;
    rd_ready = rr;
  endtask

  task automatic idle();
    drive(0, 8'h00, 3'b000, 0);
    flush   = 0;
    ovr_clr = 0;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 fill in reset", int'(fill), 0);
    chk("R1 wr_ready in reset", int'(wr_ready), 1);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 fill after reset", int'(fill), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rx_req", int'(rx_req), 0);
    chk("R1 err_any", int'(err_any), 0);
    chk("R1 overrun", int'(overrun), 0);

    // R2/R9: tagged characters in order, err_any clears after the last tagged one
    drive(1, 8'hA1, 3'b001, 0);
    drive(1, 8'hB2, 3'b000, 0);
    drive(1, 8'hC3, 3'b100, 0);
    drive(1, 8'hD4, 3'b010, 0);
    drive(0, 8'h00, 3'b000, 0);
    @(posedge clk); #1;
    chk("R2 first head", int'(rd_data), 'hA1);
    chk("R9 err_any set", int'(err_any), 1);
    drive(0, 8'h00, 3'b000, 1);
    drive(0, 8'h00, 3'b000, 1);
    drive(0, 8'h00, 3'b000, 1);
    drive(0, 8'h00, 3'b000, 1);
    idle();
    @(posedge clk); #1;
    chk("R9 err_any clear", int'(err_any), 0);

    // R7 trigger level sweep with R4 full and overrun
    trig_sel = 2'd3;
    for (int i = 0; i < D; i++) drive(1, 8'(i + 16), 3'b000, 0);
    idle();
    @(posedge clk); #1;
    chk("R3 full fill", int'(fill), D);
    chk("R7 req at full", int'(rx_req), 1);
    rx_int_en = 0;
    @(posedge clk); #1;
    chk("R8 req gated", int'(rx_req), 0);
    rx_int_en = 1;
    drive(1, 8'hEE, 3'b111, 0);
    idle();
    @(posedge clk); #1;
    chk("R4 overrun set", int'(overrun), 1);
    chk("R4 drop ignored err", int'(err_any), 0);
    chk("R4 head unchanged", int'(rd_data), 16);

    // R5 full read+write, then R6 clear vs drop
    drive(1, 8'h5A, 3'b000, 1);
    @(negedge clk); ovr_clr = 1; wr_valid = 0; rd_ready = 0;
    idle();
    @(posedge clk); #1;
    chk("R5 fill stays full", int'(fill), D);
    chk("R6 overrun cleared", int'(overrun), 0);
    drive(1, 8'h77, 3'b000, 0);
    ovr_clr = 1;
    idle();
    @(posedge clk); #1;
    chk("R6 set beats clear", int'(overrun), 1);

    // R10 flush races a write
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    drive(0, 8'h00, 3'b000, 1);
    drive(1, 8'h99, 3'b010, 0);
    flush = 1;
    idle();
    @(posedge clk); #1;
    chk("R10 flush fill", int'(fill), 0);
    chk("R10 no overrun", int'(overrun), 0);

    // R7 each level, filling from empty
    for (int c = 0; c < 4; c++) begin
      trig_sel = 2'(c);
      for (int i = 0; i < lvl(2'(c)) - 1; i++) drive(1, 8'(i), 3'b000, 0);
      idle();
      @(posedge clk); #1;
      chk("R7 below level", int'(rx_req), 0);
      drive(1, 8'h42, 3'b000, 0);
      idle();
      @(posedge clk); #1;
      chk("R7 at level", int'(rx_req), 1);
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
    end

    // Mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 2) == 0, 8'($urandom), 3'(($urandom % 4 == 0) ? $urandom : 0),
            ($urandom % 5) < 2 + (n / 1000) % 2);
      flush   = ($urandom % 97) == 0;
      ovr_clr = ($urandom % 13) == 0;
      if ($urandom % 50 == 0) trig_sel = 2'($urandom);
      if ($urandom % 40 == 0) rx_int_en = ~rx_int_en;
    end
    idle();
    repeat (3) @(posedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    total++;
    bad++;
    $display("FAIL R1-watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule